// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block decides, cycle by cycle, whether the single instruction waiting at an in-order issue stage may be dispatched to one of four functional units: a one-cycle integer unit, a one-cycle adder, a three-cycle pipelined multiplier and a four-cycle unpipelined divider. It keeps a write-pending flag for every architectural register and derives a busy flag for every unit. It refuses dispatch on a read-after-write or write-after-write hazard, on a busy unit, or when the new result would reach the shared write-back port in the same cycle as a result already in flight.

Inside, each unit carries an occupancy flag, a write flag and a destination tag down its stages. When a tagged operation leaves the last stage, the block drives the single write-back port and clears that register's pending flag. The issuing stage holds its request until the grant appears. Source operands are assumed to be captured by the unit at dispatch, so no write-after-read check exists.

Top module: `issue_scoreboard`

## Requirements
- R1: After a synchronous active-low reset no register is pending, `unit_busy` is 0 and `wb_valid` is 0, so any instruction is granted in the first cycle.
- R2: `iss_grant` is high only while `iss_valid` is high. A granted instruction with a destination appears on `wb_valid`/`wb_dst` exactly L cycles after its grant cycle, where unit code 0 (integer) and 1 (adder) have L=1, code 2 (multiplier) has L=3 and code 3 (divider) has L=4. That write-back clears the register's pending flag.
- R3: A request is refused while either source register (`iss_src_a`, `iss_src_b`) has a pending write.
- R4: A request with `iss_has_dst` high is refused while its destination has a pending write, so a register is never pending twice.
- R5: A destination that is only a source of an instruction in flight causes no refusal.
- R6: A pending flag cleared by write-back in the current cycle counts as clear for the request in that same cycle, for sources and destination alike.
- R7: `unit_busy[3]` is high in each of the four cycles after a divider grant, and a divider request is refused while it is high. Bits 0 to 2 stay low, and the multiplier accepts back-to-back requests.
- R8: A request with a destination is refused if its write-back cycle equals that of any result already in flight, so at most one result uses the port per cycle.
- R9: A request with `iss_has_dst` low skips the write-after-write and port checks, sets no pending flag and produces no write-back. It still occupies its unit, so a divider without a destination still makes the divider busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is waiting at issue |
| iss_unit | input | 2 | Target unit: 0 integer, 1 adder, 2 multiplier, 3 divider |
| iss_has_dst | input | 1 | The instruction writes a register |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_grant | output | 1 | The instruction dispatches this cycle |
| unit_busy | output | 4 | Per-unit busy flag, bit index equals unit code |
| wb_valid | output | 1 | A result uses the write-back port this cycle |
| wb_dst | output | REG_W | Register written back this cycle |

## Verification
Assertions check on every cycle that at most one unit drives the write-back port, and that every written-back register was pending. They also check that a set pending flag is visible on the next cycle and that a cleared one is gone. For the divider they check that it never holds more than one operation and is never handed a new one while busy. The timing of each result, the same-cycle clear bypass, refusals caused by port collisions and the absence of a write-after-read check only show up against the bench's reference model. That model replays a fixed set of hazard scenarios and then a long run of random requests on a small register window.

// File: rtl/sb_pkg.sv
// Shared definitions for the issue scoreboard.
// Assumes exactly four functional units, addressed by a 2-bit code.
package sb_pkg;
    localparam int N_UNITS = 4;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } unit_e;

    // Largest of four latencies, used to size reservation vectors.
    function automatic int max_lat(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/sb_unit_pipe.sv
// Tag pipeline of one functional unit: carries occupancy, write flag and
// destination through LAT stages. Reports write-back from the last stage and a
// vector marking how many cycles remain before each tagged result leaves.
// Assumes LAT >= 1 and LAT <= MAXL. An unpipelined unit is busy while occupied.
module sb_unit_pipe #(
    parameter int LAT       = 1,
    parameter bit PIPELINED = 1'b1,
    parameter int REG_W     = 5,
    parameter int MAXL      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             acc_we,
    input  logic [REG_W-1:0] acc_dst,
    output logic             busy,
    output logic             wb_req,
    output logic [REG_W-1:0] wb_dst,
    output logic [MAXL:0]    remain
);
    logic [LAT-1:0]   occ_q;
    logic [LAT-1:0]   we_q;
    logic [REG_W-1:0] dst_q [LAT];

    // Shift occupancy and write flags one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            we_q  <= '0;
        end else begin
            occ_q[0] <= accept;
            we_q[0]  <= accept & acc_we;
            for (int s = 1; s < LAT; s++) begin
                occ_q[s] <= occ_q[s-1];
                we_q[s]  <= we_q[s-1];
            end
        end
    end

    // Shift destination tags alongside the flags (data, no reset needed).
    always_ff @(posedge clk) begin
        dst_q[0] <= acc_dst;
        for (int s = 1; s < LAT; s++) dst_q[s] <= dst_q[s-1];
    end

    // Mark each tagged result by the cycles left until it leaves the unit.
    always_comb begin
        remain = '0;
        for (int s = 0; s < LAT; s++)
            if (occ_q[s] && we_q[s]) remain[LAT-1-s] = 1'b1;
    end

    assign wb_req = occ_q[LAT-1] & we_q[LAT-1];
    assign wb_dst = dst_q[LAT-1];

    generate
        if (PIPELINED) begin : g_piped
            assign busy = 1'b0;
        end else begin : g_unpiped
            assign busy = |occ_q;

            // R7
            unpiped_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(occ_q) <= 1);
            // R7
            unpiped_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                busy |-> !accept);
        end
    endgenerate
endmodule

// File: rtl/sb_pending_regs.sv
// Write-pending flags, one per register. Write-back clears and issue sets; a
// set wins over a clear of the same register. Lookups see this cycle's clear.
// Assumes at most one set and one clear per cycle.
module sb_pending_regs #(
    parameter int NREG  = 32,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [REG_W-1:0] set_r,
    input  logic             clr_v,
    input  logic [REG_W-1:0] clr_r,
    input  logic [REG_W-1:0] look_a,
    input  logic [REG_W-1:0] look_b,
    input  logic [REG_W-1:0] look_d,
    output logic             hit_a,
    output logic             hit_b,
    output logic             hit_d,
    output logic [NREG-1:0]  pend_q
);
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] pend_eff;

    // Decode set and clear requests into register masks.
    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        if (clr_v) clr_mask[clr_r] = 1'b1;
        if (set_v) set_mask[set_r] = 1'b1;
    end

    assign pend_eff = pend_q & ~clr_mask;
    assign hit_a    = pend_eff[look_a];
    assign hit_b    = pend_eff[look_b];
    assign hit_d    = pend_eff[look_d];

    // Update the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_eff | set_mask;
    end

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |=> pend_q[$past(set_r)]);
    // R2
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !(set_v && set_r == clr_r)) |=> !pend_q[$past(clr_r)]);
endmodule

// File: rtl/sb_issue_check.sv
// Combinational dispatch decision: unit availability, RAW, WAW and write-back
// port reservation. Assumes the pending hits already include this cycle's clear.
module sb_issue_check #(
    parameter int L_INT = 1,
    parameter int L_ADD = 1,
    parameter int L_MUL = 3,
    parameter int L_DIV = 4,
    parameter int MAXL  = 4
) (
    input  logic                        req_v,
    input  sb_pkg::unit_e               unit,
    input  logic                        has_dst,
    input  logic                        hit_a,
    input  logic                        hit_b,
    input  logic                        hit_d,
    input  logic [sb_pkg::N_UNITS-1:0]  busy,
    input  logic [MAXL:0]               resv,
    output logic                        grant
);
    logic port_clash;
    logic hazard;

    // Look up whether the write-back slot of the requested unit is taken.
    always_comb begin
        unique case (unit)
            sb_pkg::UNIT_INT: port_clash = resv[L_INT];
            sb_pkg::UNIT_ADD: port_clash = resv[L_ADD];
            sb_pkg::UNIT_MUL: port_clash = resv[L_MUL];
            default:          port_clash = resv[L_DIV];
        endcase
    end

    // Combine all reasons to hold the instruction back.
    always_comb begin
        hazard = busy[unit] | hit_a | hit_b;
        if (has_dst) hazard = hazard | hit_d | port_clash;
    end

    assign grant = req_v & ~hazard;
endmodule

// File: rtl/issue_scoreboard.sv
// In-order issue scoreboard for four functional units of fixed latency.
// Grants the waiting instruction when its unit is free, its sources and
// destination are not pending and its result slot on the single write-back
// port is free. Assumes operands are captured at dispatch (no WAR check) and
// that the issuing stage holds its request until granted.
module issue_scoreboard #(
    parameter int       NUM_REGS  = 32,
    parameter int       LAT_INT   = 1,
    parameter int       LAT_ADD   = 1,
    parameter int       LAT_MUL   = 3,
    parameter int       LAT_DIV   = 4,
    parameter bit [3:0] PIPE_MASK = 4'b0111,
    localparam int      REG_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [1:0]       iss_unit,
    input  logic             iss_has_dst,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src_a,
    input  logic [REG_W-1:0] iss_src_b,
    output logic             iss_grant,
    output logic [3:0]       unit_busy,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_dst
);
    import sb_pkg::*;

    localparam int MAXL = max_lat(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);

    function automatic int lat_of(input int u);
        case (u)
            0:       return LAT_INT;
            1:       return LAT_ADD;
            2:       return LAT_MUL;
            default: return LAT_DIV;
        endcase
    endfunction

    logic [N_UNITS-1:0]            u_busy;
    logic [N_UNITS-1:0]            u_wb;
    logic [N_UNITS-1:0][REG_W-1:0] u_dst;
    logic [N_UNITS-1:0][MAXL:0]    u_remain;
    logic [MAXL:0]                 resv;
    logic                          hit_a, hit_b, hit_d;
    logic [NUM_REGS-1:0]           pend_q;

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            sb_unit_pipe #(
                .LAT       (lat_of(u)),
                .PIPELINED (PIPE_MASK[u]),
                .REG_W     (REG_W),
                .MAXL      (MAXL)
            ) i_pipe (
                .clk     (clk),
                .rst_n   (rst_n),
                .accept  (iss_grant && iss_unit == 2'(u)),
                .acc_we  (iss_has_dst),
                .acc_dst (iss_dst),
                .busy    (u_busy[u]),
                .wb_req  (u_wb[u]),
                .wb_dst  (u_dst[u]),
                .remain  (u_remain[u])
            );
        end
    endgenerate

    // Merge unit reservations and select the unit that owns the port.
    always_comb begin
        resv   = '0;
        wb_dst = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            resv = resv | u_remain[u];
            if (u_wb[u]) wb_dst = wb_dst | u_dst[u];
        end
    end

    assign wb_valid  = |u_wb;
    assign unit_busy = u_busy;

    sb_pending_regs #(
        .NREG  (NUM_REGS),
        .REG_W (REG_W)
    ) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (iss_grant & iss_has_dst),
        .set_r  (iss_dst),
        .clr_v  (wb_valid),
        .clr_r  (wb_dst),
        .look_a (iss_src_a),
        .look_b (iss_src_b),
        .look_d (iss_dst),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .hit_d  (hit_d),
        .pend_q (pend_q)
    );

    sb_issue_check #(
        .L_INT (LAT_INT),
        .L_ADD (LAT_ADD),
        .L_MUL (LAT_MUL),
        .L_DIV (LAT_DIV),
        .MAXL  (MAXL)
    ) i_check (
        .req_v   (iss_valid),
        .unit    (unit_e'(iss_unit)),
        .has_dst (iss_has_dst),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .hit_d   (hit_d),
        .busy    (u_busy),
        .resv    (resv),
        .grant   (iss_grant)
    );

    // R8
    wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(u_wb));
    // R4
    wb_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend_q[wb_dst]);
endmodule

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_unit = '0;
    logic          iss_has_dst = 1'b0;
    logic [RW-1:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic          iss_grant;
    logic [3:0]    unit_busy;
    logic          wb_valid;
    logic [RW-1:0] wb_dst;

    issue_scoreboard i_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_has_dst(iss_has_dst), .iss_dst(iss_dst), .iss_src_a(iss_src_a),
        .iss_src_b(iss_src_b), .iss_grant(iss_grant), .unit_busy(unit_busy),
        .wb_valid(wb_valid), .wb_dst(wb_dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int  n_cmp = 0, n_bad = 0;
    int  cyc = 0;
    int  div_until = -1;
    bit  pend [NREG];
    int  wb_at [int];
    bit  last_grant;
    bit  done = 1'b0;
    int  lat [4] = '{1, 1, 3, 4};

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step(input bit v, input int u, input bit hd, input int d,
                        input int s1, input int s2, input string tag);
        bit exp_wbv, exp_g, coll, pa, pb, pd;
        int exp_wbd;
        bit [3:0] exp_busy;
        @(negedge clk);
        iss_valid = v; iss_unit = 2'(u); iss_has_dst = hd;
        iss_dst = RW'(d); iss_src_a = RW'(s1); iss_src_b = RW'(s2);
        #1;
        exp_wbv = wb_at.exists(cyc);
        exp_wbd = exp_wbv ? wb_at[cyc] : 0;
        pa = pend[s1] && !(exp_wbv && exp_wbd == s1);
        pb = pend[s2] && !(exp_wbv && exp_wbd == s2);
        pd = pend[d]  && !(exp_wbv && exp_wbd == d);
        exp_busy = {(cyc <= div_until), 3'b000};
        coll = wb_at.exists(cyc + lat[u]);
        exp_g = v && !exp_busy[u] && !pa && !pb && !(hd && (pd || coll));
        chk(tag, "iss_grant", int'(iss_grant), int'(exp_g));
        chk("R2", "wb_valid", int'(wb_valid), int'(exp_wbv));
        if (exp_wbv) chk("R2", "wb_dst", int'(wb_dst), exp_wbd);
        chk("R7", "unit_busy", int'(unit_busy), int'(exp_busy));
        if (exp_wbv) begin
            pend[exp_wbd] = 1'b0;
            wb_at.delete(cyc);
        end
        if (exp_g) begin
            if (hd) begin
                pend[d] = 1'b1;
                wb_at[cyc + lat[u]] = d;
            end
            if (u == 3) div_until = cyc + 4;
        end
        last_grant = exp_g;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, "R2");
    endtask

    task automatic hold(input int u, input bit hd, input int d, input int s1,
                        input int s2, input string tag);
        for (int k = 0; k < 10; k++) begin
            step(1, u, hd, d, s1, s2, tag);
            if (last_grant) break;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) pend[r] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "wb_valid", int'(wb_valid), 0);
        chk("R1", "unit_busy", int'(unit_busy), 0);
        step(1, 0, 1, 1, 2, 3, "R1");
        idle(2);

        // R2: every unit, spaced apart; plus a request held low
        step(0, 2, 1, 4, 0, 0, "R2");
        step(1, 0, 1, 2, 0, 0, "R2");
        idle(2);
        step(1, 1, 1, 3, 0, 0, "R2");
        idle(2);
        step(1, 2, 1, 4, 0, 0, "R2");
        idle(4);
        step(1, 3, 1, 5, 0, 0, "R2");
        idle(5);

        // R3: RAW on each source
        step(1, 2, 1, 6, 0, 0, "R3");
        hold(1, 1, 7, 6, 0, "R3");
        step(1, 2, 1, 8, 0, 0, "R3");
        hold(0, 1, 9, 1, 8, "R3");
        idle(4);

        // R4: WAW behind the divider
        step(1, 3, 1, 10, 0, 0, "R4");
        hold(0, 1, 10, 0, 0, "R4");
        idle(5);

        // R6: same-cycle clear bypass on source and destination
        step(1, 0, 1, 11, 0, 0, "R6");
        step(1, 1, 1, 12, 11, 0, "R6");
        step(1, 0, 1, 12, 0, 0, "R6");
        idle(3);

        // R5: destination equals a source of an in-flight instruction
        step(1, 2, 1, 13, 14, 15, "R5");
        step(1, 1, 1, 14, 0, 0, "R5");
        idle(4);

        // R7: divider back-to-back, multiplier back-to-back
        step(1, 3, 1, 16, 0, 0, "R7");
        hold(3, 1, 17, 0, 0, "R7");
        idle(5);
        step(1, 2, 1, 18, 0, 0, "R7");
        step(1, 2, 1, 19, 0, 0, "R7");
        idle(4);

        // R8: write-back port collision
        step(1, 2, 1, 20, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R8");
        hold(0, 1, 21, 0, 0, "R8");
        idle(4);
        step(1, 3, 1, 22, 0, 0, "R8");
        hold(2, 1, 23, 0, 0, "R8");
        idle(5);

        // R9: no destination
        step(1, 3, 0, 24, 0, 0, "R9");
        hold(3, 0, 24, 0, 0, "R9");
        idle(5);
        step(1, 2, 1, 25, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 25, 0, 0, "R9");
        idle(4);

        // Random run on a small register window
        for (int k = 0; k < 2000; k++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 4) != 0,
                 $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), "R2");
        idle(6);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule